// File: doc/BRIEF.md
# Watchdog Timer with Fixed Prescaler

This block guards against software lock-up. A slow-clock enable pulse, one system-clock cycle wide per slow-clock period, drives a fixed divide-by-128 prescaler. Each time the prescaler wraps, a 16-bit down counter steps down by one. Software programs a reload value and two enable flags through a mode write, and keeps the timer alive by issuing control writes that carry the restart flag. If the counter runs out first, an active-low overflow flag latches. That flag can also raise a system reset request and an interrupt.

The sequencing is a two-state machine. In `ST_RUN` the prescaler and counter advance. In `ST_EXPIRED` both hold and the counter sits at zero. The transitions are:
- `RUN_RELOAD`: a mode write or restart in `ST_RUN` stays in `ST_RUN`.
- `RUN_EXPIRE`: the last prescaler wrap goes from `ST_RUN` to `ST_EXPIRED`.
- `EXP_HOLD`: with no reload, `ST_EXPIRED` stays put.
- `EXP_RELOAD`: a mode write or restart returns from `ST_EXPIRED` to `ST_RUN`.

The overflow latch is separate from the state. It is cleared only by reset or by a status-clear strobe. With a 32.768 kHz slow clock the longest period is 65536 × 128 slow cycles, which is 256 s.

Top module: `sc_watchdog`

## Requirements
- R1: After reset the reload value is 16'hFFFF, both enables are 0, the counter reads 16'hFFFF, the state is `ST_RUN`, `wdovf_n` is 1, and `rst_req` and `irq` are 0.
- R2: A one-cycle `mode_wr` captures `mode_data` and loads the counter with the new reload value on the next clock edge. It also clears the prescaler. The fields are: bits [15:0] reload value, bit 16 reset enable, bit 17 interrupt enable.
- R3: In `ST_RUN` the counter decreases by exactly one after every 128 clock cycles in which `slow_tick` is high. Cycles with `slow_tick` low are not counted.
- R4: A `ctrl_wr` with `ctrl_restart` high reloads the counter from the stored reload value and clears the prescaler, so the next decrement needs a full 128 ticks.
- R5: A `ctrl_wr` with `ctrl_restart` low leaves the counter and prescaler unchanged.
- R6: When the prescaler wraps while the counter holds 1 or 0, the counter becomes 0, the state becomes `ST_EXPIRED`, and `wdovf_n` goes low after that same edge. From then on the counter stays at 0 until a reload.
- R7: `wdovf_n` stays low until reset or a `stat_clr` strobe. A restart or mode write does not clear it. If `stat_clr` and an expiry occur in the same cycle, the expiry wins.
- R8: `rst_req` equals the latched overflow ANDed with the reset enable, and `irq` equals the latched overflow ANDed with the interrupt enable, both using the currently stored enables.
- R9: When signals coincide in one cycle, `mode_wr` takes priority over a restart, and a restart takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock period |
| mode_wr | input | 1 | Mode register write strobe |
| mode_data | input | 18 | {irq enable, reset enable, reload[15:0]} |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_restart | input | 1 | Restart flag carried by a control write |
| stat_clr | input | 1 | Clears the latched overflow |
| cnt_val | output | 16 | Current counter value |
| wdovf_n | output | 1 | Latched overflow, active low |
| rst_req | output | 1 | System reset request |
| irq | output | 1 | Watchdog interrupt |

## Verification
Every result is due one clock edge after the stimulus cycle. A write, clear or tick applied during a cycle is visible on `cnt_val`, `wdovf_n`, `rst_req` and `irq` after the next rising edge. The bench drives each stimulus at a falling edge and removes it at the following falling edge, where it also samples the outputs. A tick run of N cycles is therefore checked at the falling edge right after the Nth edge. This lets the bench hit the exact cycle of each prescaler wrap: one tick short of 128 leaves the count unchanged, and the 128th tick moves it.

// File: rtl/sc_watchdog_pkg.sv
package sc_watchdog_pkg;
    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_EXPIRED = 1'b1
    } wd_state_t;
endpackage

// File: rtl/sc_wd_prescaler.sv
module sc_wd_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic wrap
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    assign wrap = en && (div_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr || wrap) begin
            div_q <= '0;
        end else if (en) begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/sc_wd_downcount.sv
module sc_wd_downcount #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] val,
    output logic          last
);
    logic [CW-1:0] val_q;

    assign val  = val_q;
    assign last = (val_q <= CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '1;
        end else if (load) begin
            val_q <= load_val;
        end else if (dec) begin
            val_q <= last ? '0 : val_q - 1'b1;
        end
    end
endmodule

// File: rtl/sc_watchdog.sv
module sc_watchdog
    import sc_watchdog_pkg::*;
#(
    parameter int CW  = 16,
    parameter int DIV = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_tick,
    input  logic          mode_wr,
    input  logic [CW+1:0] mode_data,
    input  logic          ctrl_wr,
    input  logic          ctrl_restart,
    input  logic          stat_clr,
    output logic [CW-1:0] cnt_val,
    output logic          wdovf_n,
    output logic          rst_req,
    output logic          irq
);
    localparam int RST_EN_BIT = CW;
    localparam int IRQ_EN_BIT = CW + 1;

    wd_state_t     state_q, state_d;
    logic [CW-1:0] reload_q;
    logic          rst_en_q, irq_en_q, ovf_q;
    logic          restart, reload_now, running, wrap, last, expire;
    logic [CW-1:0] load_val;

    assign restart    = ctrl_wr && ctrl_restart;
    assign reload_now = mode_wr || restart;
    assign load_val   = mode_wr ? mode_data[CW-1:0] : reload_q;
    assign running    = (state_q == ST_RUN) && !reload_now;
    assign expire     = wrap && last;

    sc_wd_prescaler #(.DIV(DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (reload_now),
        .en    (running && slow_tick),
        .wrap  (wrap)
    );

    sc_wd_downcount #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload_now),
        .load_val (load_val),
        .dec      (wrap),
        .val      (cnt_val),
        .last     (last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (reload_now)  state_d = ST_RUN;      // RUN_RELOAD
                else if (expire) state_d = ST_EXPIRED;  // RUN_EXPIRE
            end
            ST_EXPIRED: begin
                if (reload_now)  state_d = ST_RUN;      // EXP_RELOAD
                else             state_d = ST_EXPIRED;  // EXP_HOLD
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            reload_q <= '1;
            rst_en_q <= 1'b0;
            irq_en_q <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (mode_wr) begin
                reload_q <= mode_data[CW-1:0];
                rst_en_q <= mode_data[RST_EN_BIT];
                irq_en_q <= mode_data[IRQ_EN_BIT];
            end
            if (expire)        ovf_q <= 1'b1;
            else if (stat_clr) ovf_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        wdovf_n = !ovf_q;
        rst_req = ovf_q && rst_en_q;
        irq     = ovf_q && irq_en_q;
    end
endmodule

// File: rtl/sc_watchdog_chk.sv
module sc_watchdog_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          slow_tick,
    input logic          mode_wr,
    input logic          ctrl_wr,
    input logic          ctrl_restart,
    input logic          stat_clr,
    input logic [CW-1:0] reload,
    input logic [CW-1:0] cnt_val,
    input logic          wdovf_n,
    input logic          rst_req,
    input logic          irq
);
    // R4: restart loads the stored reload value
    p_restart_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_restart && !mode_wr) |=> (cnt_val == $past(reload)));

    // R5: a plain control write with no tick changes nothing
    p_plain_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_restart && !mode_wr && !slow_tick) |=> $stable(cnt_val));

    // R6: overflow only appears together with a zero count
    p_ovf_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdovf_n) |-> (cnt_val == '0));

    // R3: without a load, the count moves down by at most one per edge
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_wr && !(ctrl_wr && ctrl_restart)) |=>
        ((cnt_val == $past(cnt_val)) || (cnt_val == $past(cnt_val) - 1'b1)));

    // R7: overflow only leaves the asserted level after a clear strobe
    p_ovf_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdovf_n && !stat_clr) |=> !wdovf_n);

    // R8: reset request and interrupt imply overflow
    p_rst_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !wdovf_n);
    p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !wdovf_n);
endmodule

bind sc_watchdog sc_watchdog_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slow_tick    (slow_tick),
    .mode_wr      (mode_wr),
    .ctrl_wr      (ctrl_wr),
    .ctrl_restart (ctrl_restart),
    .stat_clr     (stat_clr),
    .reload       (reload_q),
    .cnt_val      (cnt_val),
    .wdovf_n      (wdovf_n),
    .rst_req      (rst_req),
    .irq          (irq)
);

// File: tb/tb_sc_watchdog.sv
`timescale 1ns/1ps
module tb_sc_watchdog;
    localparam int CW = 16;
    localparam logic [2:0] OP_MODE = 3'd0, OP_RST = 3'd1, OP_POKE = 3'd2,
                           OP_TICK = 3'd3, OP_CLR = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [17:0] arg;
        logic [15:0] ticks;
        logic [15:0] exp_cnt;
        logic        exp_ovf;   // 1 = overflow latched
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{OP_MODE, 18'h30003, 16'd0,   16'd3, 1'b0},  // R2
        '{OP_TICK, 18'h0,     16'd127, 16'd3, 1'b0},  // R3
        '{OP_TICK, 18'h0,     16'd1,   16'd2, 1'b0},  // R3
        '{OP_TICK, 18'h0,     16'd100, 16'd2, 1'b0},
        '{OP_RST,  18'h0,     16'd0,   16'd3, 1'b0},  // R4
        '{OP_TICK, 18'h0,     16'd127, 16'd3, 1'b0},  // R4 prescaler cleared
        '{OP_TICK, 18'h0,     16'd1,   16'd2, 1'b0},
        '{OP_POKE, 18'h0,     16'd0,   16'd2, 1'b0},  // R5
        '{OP_TICK, 18'h0,     16'd256, 16'd0, 1'b1},  // R6
        '{OP_TICK, 18'h0,     16'd300, 16'd0, 1'b1},  // R6 hold
        '{OP_RST,  18'h0,     16'd0,   16'd3, 1'b1},  // R7
        '{OP_CLR,  18'h0,     16'd0,   16'd3, 1'b0},  // R7
        '{OP_MODE, 18'h00001, 16'd0,   16'd1, 1'b0},
        '{OP_TICK, 18'h0,     16'd128, 16'd0, 1'b1},  // R8 no enables
        '{OP_CLR,  18'h0,     16'd0,   16'd0, 1'b0},
        '{OP_MODE, 18'h10005, 16'd0,   16'd5, 1'b0},
        '{OP_TICK, 18'h0,     16'd640, 16'd0, 1'b1},  // R8 reset only
        '{OP_MODE, 18'h20002, 16'd0,   16'd2, 1'b1}   // R8 irq only, R7
    };

    logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0;
    logic mode_wr = 1'b0, ctrl_wr = 1'b0, ctrl_restart = 1'b0, stat_clr = 1'b0;
    logic [CW+1:0] mode_data = '0;
    logic [CW-1:0] cnt_val;
    logic wdovf_n, rst_req, irq;
    int checks = 0, errors = 0;
    logic rst_en_m = 1'b0, irq_en_m = 1'b0;

    always #4 clk = ~clk;

    sc_watchdog dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
        .mode_wr(mode_wr), .mode_data(mode_data),
        .ctrl_wr(ctrl_wr), .ctrl_restart(ctrl_restart), .stat_clr(stat_clr),
        .cnt_val(cnt_val), .wdovf_n(wdovf_n), .rst_req(rst_req), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [15:0] ecnt, input logic eovf);
        chk({req, " cnt"}, 32'(cnt_val), 32'(ecnt));
        chk({req, " ovf_n"}, 32'(wdovf_n), 32'(!eovf));
        chk({req, " rst_req R8"}, 32'(rst_req), 32'(eovf && rst_en_m));
        chk({req, " irq R8"}, 32'(irq), 32'(eovf && irq_en_m));
    endtask

    task automatic pulse_mode(input logic [17:0] d);
        @(negedge clk); mode_wr = 1'b1; mode_data = d;
        @(negedge clk); mode_wr = 1'b0;
        rst_en_m = d[16]; irq_en_m = d[17];
    endtask

    task automatic pulse_ctrl(input logic r);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_restart = r;
        @(negedge clk); ctrl_wr = 1'b0; ctrl_restart = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); slow_tick = 1'b1;
        repeat (n) @(negedge clk);
        slow_tick = 1'b0;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1 reset", 16'hFFFF, 1'b0);
        rst_n = 1'b1;
        // R1 reset reload and R3 advance: 128 ticks from reset yields FFFE
        ticks(128);
        chk_all("R1 R3 first step", 16'hFFFE, 1'b0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_MODE: pulse_mode(VEC[i].arg);
                OP_RST:  pulse_ctrl(1'b1);
                OP_POKE: pulse_ctrl(1'b0);
                OP_TICK: ticks(int'(VEC[i].ticks));
                default: pulse_clr();
            endcase
            chk_all($sformatf("vec%0d R2 R3 R4 R5 R6 R7", i), VEC[i].exp_cnt, VEC[i].exp_ovf);
        end

        // R3: gapped ticks, 128 high cycles spread over 256 cycles
        pulse_mode(18'h00004);
        chk_all("R2 reload 4", 16'd4, 1'b1);
        pulse_clr();
        for (int k = 0; k < 127; k++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
        chk_all("R3 gaps 127", 16'd4, 1'b0);
        @(negedge clk); slow_tick = 1'b1;
        @(negedge clk); slow_tick = 1'b0;
        chk_all("R3 gaps 128", 16'd3, 1'b0);

        // R6: zero reload expires after one prescale period
        pulse_mode(18'h10000);
        ticks(127);
        chk_all("R6 zero reload early", 16'd0, 1'b0);
        ticks(1);
        chk_all("R6 zero reload expire", 16'd0, 1'b1);

        // R7: clear in the expiry cycle loses to the expiry
        pulse_clr();
        pulse_mode(18'h10001);
        ticks(127);
        @(negedge clk); slow_tick = 1'b1; stat_clr = 1'b1;
        @(negedge clk); slow_tick = 1'b0; stat_clr = 1'b0;
        chk_all("R7 clear vs expire", 16'd0, 1'b1);

        // R9: mode write beats restart in the same cycle
        @(negedge clk); mode_wr = 1'b1; mode_data = 18'h00009; ctrl_wr = 1'b1; ctrl_restart = 1'b1;
        @(negedge clk); mode_wr = 1'b0; ctrl_wr = 1'b0; ctrl_restart = 1'b0;
        rst_en_m = 1'b0; irq_en_m = 1'b0;
        chk_all("R9 mode over restart", 16'd9, 1'b1);
        // R9: restart beats a prescaler wrap in the same cycle
        pulse_clr();
        ticks(127);
        @(negedge clk); slow_tick = 1'b1; ctrl_wr = 1'b1; ctrl_restart = 1'b1;
        @(negedge clk); slow_tick = 1'b0; ctrl_wr = 1'b0; ctrl_restart = 1'b0;
        chk_all("R9 restart over count", 16'd9, 1'b0);
        ticks(127);
        chk_all("R9 R4 prescaler cleared", 16'd9, 1'b0);

        // R1: reset while overflow is latched
        pulse_mode(18'h30001);
        ticks(128);
        chk_all("R6 before reset", 16'd0, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        rst_en_m = 1'b0; irq_en_m = 1'b0;
        @(negedge clk);
        chk_all("R1 reset clears overflow", 16'hFFFF, 1'b0);
        rst_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule